// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write a 32K x 8 asynchronous static RAM. On the user side a request is held high together with an operation flag, an address and write data until the block answers with a one-cycle acknowledge. For a read, the acknowledge arrives with the returned byte on the read data port. On the memory side the block drives the address bus, the three active-low strobes (chip select, write enable, output enable) and the outgoing half of the data bus with an explicit drive enable. The pad-level tri-state buffer sits outside the block.

Every phase lasts a whole number of clock cycles. The counts are worked out at elaboration from a clock-period parameter and from the nanosecond limits of the memory. A read is held for the longest of the read cycle, address access and output-enable access times. A write is held for the longest of the write cycle, write pulse width, address-to-write-end and data-setup times. After every read the block leaves the bus alone long enough for the memory to release it, so the next access cannot collide with it.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, chip select, write enable and output enable are high (1), the drive enable is low (0) and acknowledge is low.
- R2: A read holds chip select low, output enable low and write enable high for exactly RD_N = max(ceil(T_RD_CYCLE/P), ceil(T_ADDR_ACC/P), ceil(T_OE_ACC/P)) cycles, where P is the clock period in ns and each ceiling is at least 1. With the defaults this is 9 cycles at P=10 and 4 at P=25.
- R3: The byte on the memory data input in the last cycle of the read phase appears on the read data port in the cycle where acknowledge is high.
- R4: A write holds chip select low, write enable low and output enable high for exactly WR_N = max(ceil(T_WR_CYCLE/P), ceil(T_WE_PULSE/P), ceil(T_ADDR_TO_WEND/P), ceil(T_DATA_SETUP/P)) cycles, with the request's byte on the outgoing data bus throughout. This is 9 cycles at P=10 and 4 at P=25.
- R5: The data drive enable is high in exactly those cycles where chip select and write enable are both low.
- R6: After a read phase, chip select stays high for at least HZ_N+1 cycles before the next access starts, where HZ_N = ceil(T_BUS_REL/P). This is 3 cycles at P=10 and 2 at P=25.
- R7: Chip select goes high for at least one cycle between any two transactions, and it is high in the cycle where acknowledge is high.
- R8: Acknowledge is high for exactly one cycle per transaction. That cycle is the first cycle after the strobes are released, and acknowledge is never high at any other time.
- R9: A request is taken only when the block is idle and acknowledge is low. A request held high is served exactly once. Operation, address and write data are captured when the request is taken, so later changes on those inputs have no effect on the transaction in progress.
- R10: The memory address equals the captured request address and stays stable for every cycle in which chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Transaction request, held until acknowledge |
| op_wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read byte, valid when ack is high after a read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | DATA_W | Outgoing data to the pad buffer |
| mem_dq_oe | output | 1 | Pad buffer drive enable |
| mem_dq_in | input | DATA_W | Incoming data from the pad buffer |

## Verification
A request is taken at the first clock edge where the block is idle and the request is high. The strobes change at that same edge and stay low for RD_N or WR_N cycles. Acknowledge, and for reads the captured byte, appear in the first cycle after chip select rises. Once a read ends, the next chip-select fall cannot come sooner than HZ_N+1 cycles later. The bench samples every output at the falling clock edge, measures the length of each low phase and each high gap, and pops its expected item from the scoreboard exactly in the cycle where chip select rises. It runs the same traffic against two instances, built for 10 ns and 25 ns periods, so that every count is checked at two different values.

// File: rtl/asram_pkg.sv
// Package: shared types and elaboration-time helpers for the asynchronous
// SRAM controller. Assumes all timing limits are positive integers in ns.
package asram_pkg;

    // Sequencer states; one per bus phase.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_RREL  = 2'd2,
        ST_WRITE = 2'd3
    } asram_state_e;

    // Strobe set presented to the memory pins (active-low strobes).
    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } asram_strobe_t;

    // Whole cycles needed to cover a ns limit, never fewer than one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe pattern that belongs to a sequencer state.
    function automatic asram_strobe_t strobe_of(input asram_state_e st);
        asram_strobe_t s;
        s = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        case (st)
            ST_READ:  s = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
            ST_WRITE: s = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
            default:  s = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Phase timer: a down counter loaded at the start of each bus phase.
// done is high in the last cycle of a phase of length load_val+1.
// Assumes load and a non-zero count never need to be honoured together.
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The phase ends when the count has reached zero.
    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
// Sequencer: walks idle -> read -> bus release -> idle, or idle -> write ->
// idle. It takes a request only when idle and acknowledge is low, and it
// reports the capture and completion events to the datapath. Assumes the
// phase counts are at least one.
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_N  = 9,
    parameter int WR_N  = 9,
    parameter int HZ_N  = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             op_wr,
    input  logic             ack_q,
    input  logic             timer_done,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             accept,
    output logic             rd_capture,
    output logic             wr_done,
    output asram_strobe_t    strobe_nxt
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_N - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_N - 1);
    localparam logic [CNT_W-1:0] HZ_LOAD = CNT_W'(HZ_N - 1);

    asram_state_e state_q;
    asram_state_e state_nxt;

    // Next state and phase events from the current state and timer.
    always_comb begin
        state_nxt  = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        rd_capture = 1'b0;
        wr_done    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req && !ack_q) begin
                    accept     = 1'b1;
                    timer_load = 1'b1;
                    if (op_wr) begin
                        state_nxt = ST_WRITE;
                        timer_val = WR_LOAD;
                    end else begin
                        state_nxt = ST_READ;
                        timer_val = RD_LOAD;
                    end
                end
            end
            ST_READ: begin
                if (timer_done) begin
                    rd_capture = 1'b1;
                    timer_load = 1'b1;
                    timer_val  = HZ_LOAD;
                    state_nxt  = ST_RREL;
                end
            end
            ST_RREL: begin
                if (timer_done) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (timer_done) begin
                    wr_done   = 1'b1;
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Strobes for the coming cycle, registered by the datapath.
    assign strobe_nxt = strobe_of(state_nxt);

endmodule

// File: rtl/asram_datapath.sv
// Datapath: holds the captured address and write byte, registers the memory
// strobes so the pins come straight from flops, captures the read byte and
// raises the one-cycle acknowledge. Assumes accept, rd_capture and wr_done
// are mutually exclusive.
module asram_datapath
    import asram_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              rd_capture,
    input  logic              wr_done,
    input  asram_strobe_t     strobe_nxt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ack_q;
    asram_strobe_t     strobe_q;

    // Capture the request fields when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // Register the strobes so the pins never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        end else begin
            strobe_q <= strobe_nxt;
        end
    end

    // Latch the returned byte at the end of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_capture) begin
            rdata_q <= mem_dq_in;
        end
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= rd_capture | wr_done;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_cs_n   = strobe_q.cs_n;
    assign mem_we_n   = strobe_q.we_n;
    assign mem_oe_n   = strobe_q.oe_n;
    assign mem_dq_oe  = strobe_q.drv;
    assign rdata      = rdata_q;
    assign ack        = ack_q;

endmodule

// File: rtl/asram_ctrl.sv
// Top of the asynchronous SRAM controller. It derives every phase length
// from the clock period and the memory's ns limits at elaboration, then ties
// the sequencer, phase timer and datapath together. Assumes the requester
// holds req until ack, and that the pad buffer is outside this block.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_PERIOD_NS      = 10,
    parameter int ADDR_W             = 15,
    parameter int DATA_W             = 8,
    parameter int T_RD_CYCLE_NS      = 85,
    parameter int T_ADDR_ACC_NS      = 85,
    parameter int T_OE_ACC_NS        = 45,
    parameter int T_WR_CYCLE_NS      = 85,
    parameter int T_WE_PULSE_NS      = 55,
    parameter int T_ADDR_TO_WEND_NS  = 70,
    parameter int T_DATA_SETUP_NS    = 40,
    parameter int T_BUS_REL_NS       = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              op_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_N = imax(imax(ns_to_cyc(T_RD_CYCLE_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS)),
                               ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS));
    localparam int WR_N = imax(imax(ns_to_cyc(T_WR_CYCLE_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_WE_PULSE_NS, CLK_PERIOD_NS)),
                               imax(ns_to_cyc(T_ADDR_TO_WEND_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS)));
    localparam int HZ_N  = ns_to_cyc(T_BUS_REL_NS, CLK_PERIOD_NS);
    localparam int MAX_N = imax(imax(RD_N, WR_N), HZ_N);
    localparam int CNT_W = (MAX_N < 2) ? 1 : $clog2(MAX_N);

    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_done;
    logic             accept;
    logic             rd_capture;
    logic             wr_done;
    asram_strobe_t    strobe_nxt;

    asram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    asram_seq #(
        .RD_N  (RD_N),
        .WR_N  (WR_N),
        .HZ_N  (HZ_N),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .op_wr      (op_wr),
        .ack_q      (ack),
        .timer_done (timer_done),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .accept     (accept),
        .rd_capture (rd_capture),
        .wr_done    (wr_done),
        .strobe_nxt (strobe_nxt)
    );

    asram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .rd_capture (rd_capture),
        .wr_done    (wr_done),
        .strobe_nxt (strobe_nxt),
        .addr       (addr),
        .wdata      (wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_oe  (mem_dq_oe),
        .rdata      (rdata),
        .ack        (ack)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
// Checker for the asynchronous SRAM controller, attached by bind. It watches
// only the top-level pins; the bus-release window is measured with a local
// counter, so no delay depends on a parameter.
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int T_BUS_REL_NS  = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    localparam int HZ_N = ns_to_cyc(T_BUS_REL_NS, CLK_PERIOD_NS);

    logic [15:0] since_rd_q;

    // Cycles since output enable was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rd_q <= 16'hFFFF;
        end else if (!mem_oe_n) begin
            since_rd_q <= '0;
        end else if (since_rd_q != 16'hFFFF) begin
            since_rd_q <= since_rd_q + 16'd1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ack));

    // R5
    drive_only_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_cs_n && !mem_we_n));

    // R5
    drive_in_every_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_we_n) |-> mem_dq_oe);

    // R2
    oe_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_we_n));

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R7
    ack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> mem_cs_n);

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R4
    wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    // R6
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(mem_cs_n) && !mem_we_n) |-> (since_rd_q >= 16'(HZ_N + 1)));

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .T_BUS_REL_NS  (T_BUS_REL_NS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
// Scoreboard bench: identical traffic runs against a 10 ns build and a 25 ns
// build of the controller. A driver task pushes the expected items, and a
// monitor sampling at the falling edge checks phases, gaps and results.
module asram_ctrl_bench;

    typedef struct {
        bit         wr;
        logic [14:0] a;
        logic [7:0]  d;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req   [2];
    logic        op_wr [2];
    logic [14:0] addr  [2];
    logic [7:0]  wdata [2];
    logic        ack   [2];
    logic [7:0]  rdata [2];
    logic [14:0] mem_addr [2];
    logic        cs_n  [2];
    logic        we_n  [2];
    logic        oe_n  [2];
    logic [7:0]  dq_out [2];
    logic        dq_oe [2];
    logic [7:0]  dq_in [2];

    int n_chk  = 0;
    int n_fail = 0;

    item_t      sb [2][$];
    logic [7:0] ref_mem [int];
    logic [7:0] mdl [int];
    int         n_ops [2];
    int         done_ops [2];
    int         low_cnt [2];
    int         hi_cnt [2];
    bit         prev_cs [2];
    bit         last_rd [2];
    logic [7:0] wdat_seen [2];
    bit         run_done = 1'b0;

    always #5 clk = ~clk;

    asram_ctrl #(.CLK_PERIOD_NS(10)) u_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req[0]), .op_wr(op_wr[0]),
        .addr(addr[0]), .wdata(wdata[0]), .ack(ack[0]), .rdata(rdata[0]),
        .mem_addr(mem_addr[0]), .mem_cs_n(cs_n[0]), .mem_we_n(we_n[0]),
        .mem_oe_n(oe_n[0]), .mem_dq_out(dq_out[0]), .mem_dq_oe(dq_oe[0]),
        .mem_dq_in(dq_in[0])
    );

    asram_ctrl #(.CLK_PERIOD_NS(25)) u_asram_ctrl_slow (
        .clk(clk), .rst_n(rst_n), .req(req[1]), .op_wr(op_wr[1]),
        .addr(addr[1]), .wdata(wdata[1]), .ack(ack[1]), .rdata(rdata[1]),
        .mem_addr(mem_addr[1]), .mem_cs_n(cs_n[1]), .mem_we_n(we_n[1]),
        .mem_oe_n(oe_n[1]), .mem_dq_out(dq_out[1]), .mem_dq_oe(dq_oe[1]),
        .mem_dq_in(dq_in[1])
    );

    function automatic int per_of(input int k);
        return (k == 0) ? 10 : 25;
    endfunction

    function automatic int cyc(input int ns, input int p);
        int c;
        c = (ns + p - 1) / p;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int exp_rd(input int k);
        return mx(mx(cyc(85, per_of(k)), cyc(85, per_of(k))), cyc(45, per_of(k)));
    endfunction

    function automatic int exp_wr(input int k);
        return mx(mx(cyc(85, per_of(k)), cyc(55, per_of(k))),
                  mx(cyc(70, per_of(k)), cyc(40, per_of(k))));
    endfunction

    function automatic int exp_hz(input int k);
        return cyc(30, per_of(k));
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // Push the expected item, hold the request until acknowledge.
    task automatic do_op(input int k, input bit wr, input logic [14:0] a,
                         input logic [7:0] d, input bit scramble);
        item_t it;
        int    key;
        key   = k * 65536 + int'(a);
        it.wr = wr;
        it.a  = a;
        if (wr) begin
            it.d = d;
            ref_mem[key] = d;
        end else begin
            it.d = ref_mem.exists(key) ? ref_mem[key] : 8'h00;
        end
        sb[k].push_back(it);
        n_ops[k]++;
        @(negedge clk);
        req[k]   = 1'b1;
        op_wr[k] = wr;
        addr[k]  = a;
        wdata[k] = d;
        if (scramble) begin
            // R9: change every field once the access has started
            do @(negedge clk); while (cs_n[k]);
            op_wr[k] = ~wr;
            addr[k]  = ~a;
            wdata[k] = ~d;
        end
        do @(negedge clk); while (!ack[k]);
        req[k] = 1'b0;
    endtask

    task automatic run_seq(input int k);
        do_op(k, 1'b1, 15'h0000, 8'hA5, 1'b0);
        do_op(k, 1'b1, 15'h7FFF, 8'h3C, 1'b0);
        do_op(k, 1'b0, 15'h0000, 8'h00, 1'b0);
        do_op(k, 1'b0, 15'h7FFF, 8'h00, 1'b0);
        do_op(k, 1'b1, 15'h1234, 8'h5A, 1'b1);
        do_op(k, 1'b0, 15'h1234, 8'h00, 1'b0);
        do_op(k, 1'b0, 15'h0100, 8'h00, 1'b0);
        do_op(k, 1'b1, 15'h1234, 8'hC3, 1'b0);
        do_op(k, 1'b0, 15'h1234, 8'h00, 1'b1);
        do_op(k, 1'b1, 15'h4000, 8'hFF, 1'b0);
        do_op(k, 1'b1, 15'h0001, 8'h00, 1'b0);
        do_op(k, 1'b0, 15'h4000, 8'h00, 1'b0);
        do_op(k, 1'b0, 15'h0001, 8'h00, 1'b0);
        for (int i = 0; i < 8; i++) begin
            do_op(k, 1'b1, 15'(i * 241 + 3), 8'(i * 37 + 1), 1'b0);
        end
        for (int i = 0; i < 8; i++) begin
            do_op(k, 1'b0, 15'(i * 241 + 3), 8'h00, 1'b0);
        end
    endtask

    // Monitor and memory model, sampled away from the active edge.
    always @(negedge clk) begin
        item_t f;
        int    key;
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                // R1
                chk(cs_n[k] && we_n[k] && oe_n[k] && !dq_oe[k] && !ack[k], "R1",
                    {cs_n[k], we_n[k], oe_n[k], dq_oe[k], ack[k]}, 5'b11100);
            end else begin
                // R5
                chk(dq_oe[k] == (!cs_n[k] && !we_n[k]), "R5",
                    dq_oe[k], !cs_n[k] && !we_n[k]);
                // R8
                chk(ack[k] == (cs_n[k] && !prev_cs[k]), "R8",
                    ack[k], cs_n[k] && !prev_cs[k]);
                if (!cs_n[k]) begin
                    if (prev_cs[k]) begin
                        chk(sb[k].size() != 0, "R9", sb[k].size(), 1);
                        if (last_rd[k]) begin
                            // R6
                            chk(hi_cnt[k] >= exp_hz(k) + 1, "R6", hi_cnt[k], exp_hz(k) + 1);
                        end else begin
                            // R7
                            chk(hi_cnt[k] >= 1, "R7", hi_cnt[k], 1);
                        end
                        low_cnt[k] = 0;
                    end
                    low_cnt[k]++;
                    if (sb[k].size() != 0) begin
                        f = sb[k][0];
                        // R10, R9: address is the one captured at acceptance
                        chk(mem_addr[k] == f.a, "R10", mem_addr[k], f.a);
                        if (f.wr) begin
                            chk(!we_n[k] && oe_n[k], "R4", {we_n[k], oe_n[k]}, 2'b01);
                            chk(dq_out[k] == f.d, "R4", dq_out[k], f.d);
                            wdat_seen[k] = dq_out[k];
                        end else begin
                            chk(we_n[k] && !oe_n[k], "R2", {we_n[k], oe_n[k]}, 2'b10);
                        end
                    end
                end else begin
                    if (!prev_cs[k] && sb[k].size() != 0) begin
                        f = sb[k].pop_front();
                        if (f.wr) begin
                            chk(low_cnt[k] == exp_wr(k), "R4", low_cnt[k], exp_wr(k));
                            mdl[k * 65536 + int'(f.a)] = wdat_seen[k];
                        end else begin
                            chk(low_cnt[k] == exp_rd(k), "R2", low_cnt[k], exp_rd(k));
                            // R3
                            chk(rdata[k] == f.d, "R3", rdata[k], f.d);
                        end
                        last_rd[k] = !f.wr;
                        hi_cnt[k]  = 0;
                        done_ops[k]++;
                    end
                    hi_cnt[k]++;
                end
                prev_cs[k] = cs_n[k];
            end
            key = k * 65536 + int'(mem_addr[k]);
            if (!cs_n[k] && !oe_n[k] && we_n[k]) begin
                dq_in[k] = mdl.exists(key) ? mdl[key] : 8'h00;
            end else begin
                dq_in[k] = 8'h00;
            end
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            req[k] = 1'b0; op_wr[k] = 1'b0; addr[k] = '0; wdata[k] = '0;
            dq_in[k] = '0; n_ops[k] = 0; done_ops[k] = 0; low_cnt[k] = 0;
            hi_cnt[k] = 1000; prev_cs[k] = 1'b1; last_rd[k] = 1'b0;
            wdat_seen[k] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_seq(0);
            run_seq(1);
        join
        repeat (10) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            // R9: each held request served exactly once
            chk(done_ops[k] == n_ops[k], "R9", done_ops[k], n_ops[k]);
            chk(sb[k].size() == 0, "R8", sb[k].size(), 0);
        end
        run_done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!run_done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog actual=no_ack expected=ack");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule